// File: doc/BRIEF.md
# Acquisition Trigger Sequencing Controller

This block runs the capture sequence of one data-acquisition channel. A host supplies a 4-bit operating mode, and the block answers with a 4-bit status code that tracks the sequence. Three lines are picked from a 16-line trigger bus, each by its own 4-bit index: a sample clock source, a start trigger and a stop trigger. The selected source is divided down into a pacer strobe. While a capture is active, each strobe marks one sample.

A capture can begin with a pre-trigger fill of a host-set number of samples. The block then waits for a start edge and samples until a stop edge arrives. After that it gathers a host-set number of post-stop samples. It then either parks in a done state (single-shot mode) or waits for the downstream FIFO to drain and starts over (re-arm mode). At power-on the converter may need initialization. A static input tells the block whether it does. If it does, leaving the power-on mode raises an initialization request, and sampling stays blocked until the converter acknowledges.

Top module: `acq_seq_ctrl`

## Requirements
- R1: In power-on mode (mode 0x4) status is 0x8 when `init_required_i` is 1 and 0x0 when it is 0; `init_req_o` and `sample_en_o` are 0; the legal status codes are 0x0-0x5, 0x7, 0x8, 0x9.
- R2: With `init_required_i` = 1, any mode other than 0x4 gives status 0x9 and `init_req_o` = 1, with no strobe and no sample enable, until `init_done_i` is seen high at a clock edge. Going back to mode 0x4 requires initialization again.
- R3: Reset mode (0x0), and any mode code outside 0x0-0x4, report status 0x0 and clear the sequence, the sample counter and the pacer phase.
- R4: The start and stop events are rising edges of the bus line chosen by `start_sel_i` / `stop_sel_i`. A line held high produces no further event.
- R5: While it runs, the pacer asserts `sample_stb_o` in the same cycle as every (`pace_div_i`+1)-th rising edge of the source line chosen by `src_sel_i`, counting from when it was last cleared. A divider of 0 strobes on every edge.
- R6: With a pre-trigger count of 0 the pacer is held cleared while waiting for start, and it counts from zero once the start edge arrives. With a non-zero count it keeps running through the pre-trigger fill and the wait.
- R7: A go mode (0x2 single-shot, 0x3 re-arm) entered from stopped shows status 0x1 one cycle later if the pre-trigger count is non-zero, and otherwise 0x2. During 0x1, start edges are ignored. The status moves to 0x2 after the pre-trigger count of strobes.
- R8: In status 0x2 a start edge gives status 0x3. Stop edges are ignored there.
- R9: In status 0x3 a stop edge gives status 0x4 if the post-stop count is non-zero; otherwise the capture ends at once. In 0x4 the capture ends after the post-stop count of strobes.
- R10: In single-shot mode the capture ends in status 0x7. It stays there, with no strobe or sample enable, whatever the triggers do, until the mode changes.
- R11: In re-arm mode the capture ends in status 0x5. The block holds there until `fifo_empty_i` is high at a clock edge, then shows 0x1 or 0x2 as in R7.
- R12: Paused mode (0x1) holds the status, the sample count and the pacer phase, and gives no strobe. Returning to a go mode continues from the held point.
- R13: `sample_en_o` is 1 only in a go mode with the converter ready and the status 0x1, 0x3 or 0x4, or the status 0x2 with a non-zero pre-trigger count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 4 | Host operating mode |
| init_required_i | input | 1 | Static: converter needs initialization |
| init_done_i | input | 1 | Converter initialization finished |
| trig_bus_i | input | 16 | Trigger and clock source lines |
| src_sel_i | input | 4 | Pacer source line index |
| start_sel_i | input | 4 | Start trigger line index |
| stop_sel_i | input | 4 | Stop trigger line index |
| pace_div_i | input | 16 | Pacer divider value |
| pre_count_i | input | 16 | Pre-trigger sample count |
| post_count_i | input | 16 | Post-stop sample count |
| fifo_empty_i | input | 1 | Downstream FIFO is empty |
| status_o | output | 4 | Sequence status code |
| sample_en_o | output | 1 | Capture active |
| sample_stb_o | output | 1 | Pacer sample strobe |
| init_req_o | output | 1 | Converter initialization request |

## Verification
The bench sweeps divider values 0 to 3, pre-trigger counts 0 to 2 and post-stop counts 1 and 2, in both go modes and with varying trigger lines. It counts source pulses and sends one pulse less than the expected limit, then exactly the limit, so an off-by-one in the divider or in either fill counter is caught. Trigger edges are sent in the states that must ignore them, and a stop line is held high across the start edge, which separates edge detection from level sensing. Dedicated runs cover the initialization gate, a pause in the middle of a divider period with the pacer phase carried across it, and a FIFO that is still full when the block is waiting to re-arm.

// File: rtl/acq_seq_pkg.sv
`timescale 1ns/1ps
package acq_seq_pkg;

  localparam logic [3:0] MODE_RESET  = 4'h0;
  localparam logic [3:0] MODE_PAUSE  = 4'h1;
  localparam logic [3:0] MODE_SINGLE = 4'h2;
  localparam logic [3:0] MODE_REARM  = 4'h3;
  localparam logic [3:0] MODE_UNINIT = 4'h4;

  typedef enum logic [3:0] {
    ST_STOPPED = 4'h0,
    ST_PRE     = 4'h1,
    ST_WAIT    = 4'h2,
    ST_RUN     = 4'h3,
    ST_POST    = 4'h4,
    ST_REARM   = 4'h5,
    ST_DONE    = 4'h7,
    ST_UNINIT  = 4'h8,
    ST_INIT    = 4'h9
  } status_e;

  // Pacer fires on the edge that finds the phase counter at the divider.
  function automatic logic pace_hit(input logic [31:0] phase, input logic [31:0] div);
    return phase >= div;
  endfunction

  // True when the sample now being taken is the last one of a fill.
  function automatic logic fill_last(input logic [31:0] taken, input logic [31:0] limit);
    return (taken + 32'd1) >= limit;
  endfunction

  // First state of a capture pass.
  function automatic status_e entry_state(input logic pre_nonzero);
    return pre_nonzero ? ST_PRE : ST_WAIT;
  endfunction

  // State a finished capture settles in.
  function automatic status_e end_state(input logic rearm);
    return rearm ? ST_REARM : ST_DONE;
  endfunction

endpackage

// File: rtl/acq_edge_bus.sv
`timescale 1ns/1ps
module acq_edge_bus #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] bus_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= bus_i;
  end

  assign rise_o = bus_i & ~prev_q;
endmodule

// File: rtl/acq_trig_pick.sv
`timescale 1ns/1ps
module acq_trig_pick #(
  parameter int W     = 16,
  parameter int SEL_W = 4
) (
  input  logic [W-1:0]     rise_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             evt_o
);
  assign evt_o = rise_i[sel_i];
endmodule

// File: rtl/acq_pacer.sv
`timescale 1ns/1ps
module acq_pacer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_edge_i,
  input  logic             run_i,
  input  logic             clear_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  import acq_seq_pkg::*;

  logic [DIV_W-1:0] phase_q;
  logic             step;

  assign step   = run_i && src_edge_i;
  assign tick_o = step && pace_hit(32'(phase_q), 32'(div_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (clear_i) phase_q <= '0;
    else if (tick_o)  phase_q <= '0;
    else if (step)    phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/acq_seq_fsm.sv
`timescale 1ns/1ps
module acq_seq_fsm #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       mode_i,
  input  logic             init_required_i,
  input  logic             init_done_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             tick_i,
  input  logic             fifo_empty_i,
  input  logic [CNT_W-1:0] pre_count_i,
  input  logic [CNT_W-1:0] post_count_i,
  output logic [3:0]       status_o,
  output logic             sample_en_o,
  output logic             init_req_o,
  output logic             pacer_run_o,
  output logic             pacer_clr_o
);
  import acq_seq_pkg::*;

  status_e          seq_q, seq_d, status_c;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             init_ok_q;
  logic             uninit_mode, pause_mode, go_mode, rearm_mode;
  logic             ready, flush, pre_nz, post_nz, capture_state;

  assign uninit_mode = (mode_i == MODE_UNINIT);
  assign pause_mode  = (mode_i == MODE_PAUSE);
  assign rearm_mode  = (mode_i == MODE_REARM);
  assign go_mode     = (mode_i == MODE_SINGLE) || rearm_mode;
  assign pre_nz      = (pre_count_i != '0);
  assign post_nz     = (post_count_i != '0);

  assign ready      = !init_required_i || init_ok_q;
  assign init_req_o = !uninit_mode && init_required_i && !init_ok_q;
  assign flush      = !ready || !(go_mode || pause_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       init_ok_q <= 1'b0;
    else if (uninit_mode)             init_ok_q <= 1'b0;
    else if (init_req_o && init_done_i) init_ok_q <= 1'b1;
  end

  always_comb begin
    capture_state = 1'b0;
    case (seq_q)
      ST_PRE, ST_RUN, ST_POST: capture_state = 1'b1;
      ST_WAIT:                 capture_state = pre_nz;
      default:                 capture_state = 1'b0;
    endcase
  end

  assign pacer_run_o = go_mode && ready && capture_state;
  assign pacer_clr_o = !pacer_run_o && !(pause_mode && ready);
  assign sample_en_o = pacer_run_o;

  always_comb begin
    seq_d = seq_q;
    cnt_d = cnt_q;
    if (flush) begin
      seq_d = ST_STOPPED;
      cnt_d = '0;
    end else if (go_mode) begin
      case (seq_q)
        ST_STOPPED: begin
          seq_d = entry_state(pre_nz);
          cnt_d = '0;
        end
        ST_PRE: if (tick_i) begin
          if (fill_last(32'(cnt_q), 32'(pre_count_i))) begin
            seq_d = ST_WAIT;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_WAIT: if (start_i) seq_d = ST_RUN;
        ST_RUN: if (stop_i) begin
          seq_d = post_nz ? ST_POST : end_state(rearm_mode);
          cnt_d = '0;
        end
        ST_POST: if (tick_i) begin
          if (fill_last(32'(cnt_q), 32'(post_count_i))) begin
            seq_d = end_state(rearm_mode);
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_REARM: begin
          if (!rearm_mode) begin
            seq_d = ST_DONE;
          end else if (fifo_empty_i) begin
            seq_d = entry_state(pre_nz);
            cnt_d = '0;
          end
        end
        ST_DONE: seq_d = ST_DONE;
        default: begin
          seq_d = ST_STOPPED;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q <= ST_STOPPED;
      cnt_q <= '0;
    end else begin
      seq_q <= seq_d;
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    if (uninit_mode)  status_c = init_required_i ? ST_UNINIT : ST_STOPPED;
    else if (!ready)  status_c = ST_INIT;
    else if (flush)   status_c = ST_STOPPED;
    else              status_c = seq_q;
  end

  assign status_o = status_c;
endmodule

// File: rtl/acq_seq_ctrl.sv
`timescale 1ns/1ps
module acq_seq_ctrl #(
  parameter int TRIG_W = 16,
  parameter int DIV_W  = 16,
  parameter int CNT_W  = 16,
  localparam int SEL_W = $clog2(TRIG_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        mode_i,
  input  logic              init_required_i,
  input  logic              init_done_i,
  input  logic [TRIG_W-1:0] trig_bus_i,
  input  logic [SEL_W-1:0]  src_sel_i,
  input  logic [SEL_W-1:0]  start_sel_i,
  input  logic [SEL_W-1:0]  stop_sel_i,
  input  logic [DIV_W-1:0]  pace_div_i,
  input  logic [CNT_W-1:0]  pre_count_i,
  input  logic [CNT_W-1:0]  post_count_i,
  input  logic              fifo_empty_i,
  output logic [3:0]        status_o,
  output logic              sample_en_o,
  output logic              sample_stb_o,
  output logic              init_req_o
);
  localparam int N_PICK = 3;

  logic [TRIG_W-1:0] rise;
  logic [SEL_W-1:0]  pick_sel [N_PICK];
  logic [N_PICK-1:0] pick_evt;
  logic              src_edge, start_evt, stop_evt;
  logic              pace_tick, pacer_run, pacer_clr;

  acq_edge_bus #(.W(TRIG_W)) u_edges (
    .clk    (clk),
    .rst_n  (rst_n),
    .bus_i  (trig_bus_i),
    .rise_o (rise)
  );

  assign pick_sel[0] = src_sel_i;
  assign pick_sel[1] = start_sel_i;
  assign pick_sel[2] = stop_sel_i;

  for (genvar g = 0; g < N_PICK; g++) begin : g_pick
    acq_trig_pick #(.W(TRIG_W), .SEL_W(SEL_W)) u_pick (
      .rise_i (rise),
      .sel_i  (pick_sel[g]),
      .evt_o  (pick_evt[g])
    );
  end

  assign src_edge  = pick_evt[0];
  assign start_evt = pick_evt[1];
  assign stop_evt  = pick_evt[2];

  acq_pacer #(.DIV_W(DIV_W)) u_pacer (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_edge_i (src_edge),
    .run_i      (pacer_run),
    .clear_i    (pacer_clr),
    .div_i      (pace_div_i),
    .tick_o     (pace_tick)
  );

  acq_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk             (clk),
    .rst_n           (rst_n),
    .mode_i          (mode_i),
    .init_required_i (init_required_i),
    .init_done_i     (init_done_i),
    .start_i         (start_evt),
    .stop_i          (stop_evt),
    .tick_i          (pace_tick),
    .fifo_empty_i    (fifo_empty_i),
    .pre_count_i     (pre_count_i),
    .post_count_i    (post_count_i),
    .status_o        (status_o),
    .sample_en_o     (sample_en_o),
    .init_req_o      (init_req_o),
    .pacer_run_o     (pacer_run),
    .pacer_clr_o     (pacer_clr)
  );

  assign sample_stb_o = pace_tick;
endmodule

// File: rtl/acq_seq_ctrl_chk.sv
`timescale 1ns/1ps
module acq_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] mode_i,
  input logic       fifo_empty_i,
  input logic [3:0] status_o,
  input logic       sample_en_o,
  input logic       sample_stb_o,
  input logic       init_req_o
);
  import acq_seq_pkg::*;

  AST_STB_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb_o |-> sample_en_o); // R5

  AST_NO_EN_WHILE_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    init_req_o |-> !sample_en_o); // R2

  AST_UNINIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_UNINIT) |-> (!sample_en_o && !init_req_o)); // R1

  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o != 4'h6) && (status_o <= 4'h9)); // R1

  AST_PAUSE_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_PAUSE && !init_req_o) |=> (mode_i != MODE_PAUSE) || $stable(status_o)); // R12

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == ST_DONE && mode_i == MODE_SINGLE) |=> (mode_i != MODE_SINGLE) || (status_o == ST_DONE)); // R10

  AST_REARM_WAITS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == ST_REARM && mode_i == MODE_REARM && !fifo_empty_i)
      |=> (mode_i != MODE_REARM) || (status_o == ST_REARM)); // R11
endmodule

bind acq_seq_ctrl acq_seq_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_i       (mode_i),
  .fifo_empty_i (fifo_empty_i),
  .status_o     (status_o),
  .sample_en_o  (sample_en_o),
  .sample_stb_o (sample_stb_o),
  .init_req_o   (init_req_o)
);

// File: tb/acq_seq_ctrl_bench.sv
`timescale 1ns/1ps
module acq_seq_ctrl_bench;
  localparam int SRC = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  mode = 4'h4;
  logic        init_required = 1'b1;
  logic        init_done = 1'b0;
  logic [15:0] bus = '0;
  logic [3:0]  src_sel = 4'(SRC);
  logic [3:0]  start_sel = 4'd0;
  logic [3:0]  stop_sel = 4'd1;
  logic [15:0] div = '0;
  logic [15:0] pre = '0;
  logic [15:0] post = 16'd1;
  logic        fifo_empty = 1'b0;
  logic [3:0]  status;
  logic        sample_en, stb, init_req;

  int checks = 0;
  int errors = 0;
  int strobes = 0;

  always #10 clk = ~clk;

  acq_seq_ctrl u_acq_seq_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .mode_i          (mode),
    .init_required_i (init_required),
    .init_done_i     (init_done),
    .trig_bus_i      (bus),
    .src_sel_i       (src_sel),
    .start_sel_i     (start_sel),
    .stop_sel_i      (stop_sel),
    .pace_div_i      (div),
    .pre_count_i     (pre),
    .post_count_i    (post),
    .fifo_empty_i    (fifo_empty),
    .status_o        (status),
    .sample_en_o     (sample_en),
    .sample_stb_o    (stb),
    .init_req_o      (init_req)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bus[SRC] = 1'b1;
      #1; if (stb) strobes++;
      @(negedge clk); bus[SRC] = 1'b0;
    end
    #1;
  endtask

  task automatic edge_on(input int line);
    @(negedge clk); bus[line] = 1'b1;
    @(negedge clk); bus[line] = 1'b0;
    #1;
  endtask

  task automatic drive_line(input int line, input logic v);
    @(negedge clk); bus[line] = v;
    @(negedge clk); #1;
  endtask

  task automatic set_mode(input logic [3:0] m);
    @(negedge clk); mode = m;
    @(negedge clk); #1;
  endtask

  task automatic init_ack();
    @(negedge clk); init_done = 1'b1;
    @(negedge clk); init_done = 1'b0;
    #1;
  endtask

  task automatic run_capture(input int d, input int p, input int q, input bit rearm,
                             input int st, input int sp);
    int entry;
    entry = (p != 0) ? 1 : 2;
    set_mode(4'h0);
    check("R3 reset mode stopped", int'(status), 0);
    div = 16'(d); pre = 16'(p); post = 16'(q);
    start_sel = 4'(st); stop_sel = 4'(sp);
    set_mode(rearm ? 4'h3 : 4'h2);
    check("R7 go entry status", int'(status), entry);
    strobes = 0;
    if (p == 0) begin
      pulses(d + 2);
      check("R6 pacer idle while waiting", strobes, 0);
      check("R13 no enable waiting pre=0", int'(sample_en), 0);
    end else begin
      pulses(p * (d + 1) - 1);
      check("R7 pre fill one short", int'(status), 1);
      check("R5 pre strobes one short", strobes, p - 1);
      edge_on(st);
      check("R7 start ignored in pre fill", int'(status), 1);
      pulses(1);
      check("R7 pre fill complete", int'(status), 2);
      check("R5 pre strobe count", strobes, p);
      check("R13 enable waiting pre>0", int'(sample_en), 1);
    end
    drive_line(sp, 1'b1);
    check("R8 stop ignored while waiting", int'(status), 2);
    edge_on(st);
    check("R8 start edge runs", int'(status), 3);
    check("R13 enable running", int'(sample_en), 1);
    strobes = 0;
    pulses(d);
    check("R5 no strobe before divider", strobes, 0);
    pulses(1);
    check("R5 first run strobe", strobes, 1);
    pulses(d + 1);
    check("R5 second run strobe", strobes, 2);
    check("R4 held stop level no event", int'(status), 3);
    drive_line(sp, 1'b0);
    drive_line(sp, 1'b1);
    check("R9 stop edge to post", int'(status), 4);
    drive_line(sp, 1'b0);
    strobes = 0;
    pulses(q * (d + 1) - 1);
    check("R9 post one short", int'(status), 4);
    pulses(1);
    check("R9 post strobe count", strobes, q);
    if (!rearm) begin
      check("R10 single ends done", int'(status), 7);
      strobes = 0;
      pulses(d + 1);
      edge_on(st);
      check("R10 no strobe when done", strobes, 0);
      check("R10 done sticks", int'(status), 7);
      check("R10 no enable when done", int'(sample_en), 0);
    end else begin
      check("R11 rearm wait", int'(status), 5);
      repeat (3) @(negedge clk);
      #1;
      check("R11 holds while fifo busy", int'(status), 5);
      @(negedge clk); fifo_empty = 1'b1;
      @(negedge clk); fifo_empty = 1'b0;
      #1;
      check("R11 restart after empty", int'(status), entry);
    end
  endtask

  initial begin
    #4000000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #5;
    check("R1 power-on status needs init", int'(status), 8);
    check("R1 no init request", int'(init_req), 0);
    check("R1 no sample enable", int'(sample_en), 0);
    init_required = 1'b0; #1;
    check("R1 power-on status no init", int'(status), 0);
    init_required = 1'b1; #1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    set_mode(4'h0);
    check("R2 initializing status", int'(status), 9);
    check("R2 init request", int'(init_req), 1);
    div = 0; pre = 1;
    set_mode(4'h2);
    strobes = 0;
    pulses(3);
    check("R2 no strobe before init done", strobes, 0);
    check("R2 no enable before init done", int'(sample_en), 0);
    check("R2 still initializing", int'(status), 9);
    init_ack();
    check("R2 ready stopped", int'(status), 0);
    check("R2 request dropped", int'(init_req), 0);
    @(negedge clk); #1;
    check("R2 capture starts after init", int'(status), 1);
    set_mode(4'h4);
    check("R2 back to power-on", int'(status), 8);
    set_mode(4'h0);
    check("R2 init required again", int'(status), 9);
    init_ack();
    check("R2 ready again", int'(status), 0);

    for (int d = 0; d < 4; d++)
      for (int p = 0; p < 3; p++)
        for (int q = 1; q < 3; q++)
          for (int r = 0; r < 2; r++)
            run_capture(d, p, q, r[0], (d * 3 + p) % 7, (d * 3 + p) % 7 + 7);

    set_mode(4'h0);
    set_mode(4'h9);
    check("R3 unknown mode stopped", int'(status), 0);
    set_mode(4'h0);
    div = 16'd2; pre = 16'd0; post = 16'd2;
    start_sel = 4'd2; stop_sel = 4'd5;
    set_mode(4'h2);
    edge_on(2);
    edge_on(5);
    check("R9 pause test in post", int'(status), 4);
    strobes = 0;
    pulses(4);
    check("R5 pause test pre-strobes", strobes, 1);
    set_mode(4'h1);
    check("R12 pause holds status", int'(status), 4);
    check("R12 pause no enable", int'(sample_en), 0);
    pulses(3);
    edge_on(5);
    check("R12 no strobe while paused", strobes, 1);
    check("R12 status held", int'(status), 4);
    set_mode(4'h2);
    pulses(1);
    check("R12 phase kept after resume", strobes, 1);
    check("R12 count kept after resume", int'(status), 4);
    pulses(1);
    check("R12 finish after resume", strobes, 2);
    check("R10 pause run ends done", int'(status), 7);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule